// File: doc/BRIEF.md
# March Y Memory Self-Test Sequencer

This block is a self-test engine for a small single-port synchronous RAM. After one start pulse it drives the RAM's address, write data and write enable through a full March Y pass of four elements. It works out the value each read must return and compares the RAM's read data against it. A run takes eight operations per word. That is 2048 operations for the default 256-word array.

The four elements run in a fixed order, and each has its own address direction:

| Index | Direction | Operations at each address |
|-------|-----------|----------------------------|
| 0 | ascending | write zeros |
| 1 | ascending | read zeros, write ones, read ones |
| 2 | descending | read ones, write zeros, read zeros |
| 3 | ascending | read zeros |

On the first mismatch the block latches the failing word address and the element index, and it raises a sticky fail flag. It then completes the run. At the end it drops busy and raises done for one cycle. The flag and the two diagnosis fields are valid from that cycle onward.

The RAM interface and all status pins are plain control signals. They have no valid/ready handshake, because the RAM accepts one operation on every cycle and never applies back-pressure.

Top module: `march_y_bist`

## Requirements
- R1: While reset is asserted and after it is released, busy, done, ram_we and fail are all 0.
- R2: A start pulse that is sampled while the block is idle, or in its done cycle, begins a run. Busy is 1 from the next cycle for 8N+1 cycles: 8N operation cycles plus one cycle for the final compare. In the cycle after that, busy is 0 and done is 1 for exactly one cycle.
- R3: Operation k of the run is driven in the k-th busy cycle. The order is element 0 ascending, element 1 ascending, element 2 descending from N-1 down to 0, and element 3 ascending, with each element doing the operations listed in the table above.
- R4: The "zeros" pattern is every data bit 0, and the "ones" pattern is every data bit 1, across the full DATA_W width. ram_wdata carries the pattern whenever ram_we is 1.
- R5: The RAM returns read data one cycle after the address. The read data is compared with the expected pattern in the cycle after the read operation is issued.
- R6: On the first mismatch of a run, fail is set and stays set. fail_addr holds the word address and fail_elem holds the element index (0 to 3). Later mismatches change neither field, and the run still completes all 8N operations.
- R7: A start pulse during a run has no effect on the sequence or its length.
- R8: An accepted start clears fail, fail_addr and fail_elem. A clean RAM therefore ends the run with fail at 0.
- R9: ram_we is 1 only during write operations of a run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse; accepted only when not busy |
| ram_addr | output | ADDR_W | Word address to the RAM |
| ram_wdata | output | DATA_W | Write data to the RAM |
| ram_we | output | 1 | Write enable to the RAM |
| ram_rdata | input | DATA_W | Read data from the RAM, one cycle after the address |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| fail | output | 1 | Sticky flag: a mismatch was seen in this run |
| fail_addr | output | ADDR_W | Address of the first mismatch |
| fail_elem | output | 2 | Element index of the first mismatch |

## Verification
Two functions share a cycle throughout the run.

- **Compare beside a write.** The compare of one read lands in the same cycle as the next operation. In elements 1 and 2, that next operation is a write to the same address, issued in the cycle where the previous read's data is judged. The bench RAM registers its read data, so a compare that looked at the wrong cycle would see the new write and fail a clean run. The bench therefore checks every drive cycle against a precomputed operation queue.
- **Compare beside an element change.** At address N-1, the last read of element 1 is compared while the first read of element 2 is issued. Element 3's final compare coincides with the cycle before done.

Injected faults check that the first failure is latched, and that later failures are not. The faults are a stuck-at-0 cell, a stuck-at-1 cell, and a write-coupling fault that only a descending pass can expose. Each one is judged on its expected address and element index.

// File: rtl/march_pkg.sv
package march_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_CHK  = 2'd2,
    ST_FIN  = 2'd3
  } st_e;

  typedef struct packed {
    logic is_wr;
    logic val;
    logic last_step;
  } op_t;

  localparam logic [1:0] ELEM_LAST = 2'd3;
  localparam logic [1:0] ELEM_DOWN = 2'd2;

  function automatic op_t decode_op(input logic [1:0] elem, input logic [1:0] step);
    op_t o;
    o = '{is_wr: 1'b0, val: 1'b0, last_step: 1'b1};
    case (elem)
      2'd0: o = '{is_wr: 1'b1, val: 1'b0, last_step: 1'b1};
      2'd1: begin
        o.is_wr     = (step == 2'd1);
        o.val       = (step != 2'd0);
        o.last_step = (step == 2'd2);
      end
      2'd2: begin
        o.is_wr     = (step == 2'd1);
        o.val       = (step == 2'd0);
        o.last_step = (step == 2'd2);
      end
      default: o = '{is_wr: 1'b0, val: 1'b0, last_step: 1'b1};
    endcase
    return o;
  endfunction

endpackage

// File: rtl/march_addr_gen.sv
module march_addr_gen #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              load_hi,
  input  logic              adv,
  input  logic              down,
  output logic [ADDR_W-1:0] addr,
  output logic              at_end
);
  localparam logic [ADDR_W-1:0] ADDR_MAX = {ADDR_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n)       addr <= '0;
    else if (load)    addr <= load_hi ? ADDR_MAX : '0;
    else if (adv)     addr <= down ? addr - 1'b1 : addr + 1'b1;
  end

  assign at_end = down ? (addr == '0) : (addr == ADDR_MAX);
endmodule

// File: rtl/march_seq.sv
module march_seq
  import march_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       at_end,
  output st_e        state,
  output logic [1:0] elem,
  output op_t        op,
  output logic       accept,
  output logic       load,
  output logic       load_hi,
  output logic       adv,
  output logic       down
);
  logic [1:0] step;
  logic       elem_end;

  always_comb begin
    op       = decode_op(elem, step);
    accept   = start && (state == ST_IDLE || state == ST_FIN);
    down     = (elem == ELEM_DOWN);
    elem_end = (state == ST_RUN) && op.last_step && at_end;
    load     = 1'b0;
    load_hi  = 1'b0;
    adv      = 1'b0;
    if (accept) begin
      load = 1'b1;
    end else if (state == ST_RUN && op.last_step) begin
      if (at_end) begin
        load    = (elem != ELEM_LAST);
        load_hi = (elem == ELEM_DOWN - 2'd1);
      end else begin
        adv = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      elem  <= '0;
      step  <= '0;
    end else if (accept) begin
      state <= ST_RUN;
      elem  <= '0;
      step  <= '0;
    end else begin
      case (state)
        ST_RUN: begin
          step <= op.last_step ? 2'd0 : step + 2'd1;
          if (elem_end) begin
            if (elem == ELEM_LAST) state <= ST_CHK;
            else                   elem  <= elem + 2'd1;
          end
        end
        ST_CHK:  state <= ST_FIN;
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/march_resp.sv
module march_resp #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              rd_issue,
  input  logic              exp_val,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        elem,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [1:0]        fail_elem
);
  logic              chk_vld;
  logic              chk_val;
  logic [ADDR_W-1:0] chk_addr;
  logic [1:0]        chk_elem;
  logic              mism;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_vld  <= 1'b0;
      chk_val  <= 1'b0;
      chk_addr <= '0;
      chk_elem <= '0;
    end else begin
      chk_vld  <= rd_issue;
      chk_val  <= exp_val;
      chk_addr <= addr;
      chk_elem <= elem;
    end
  end

  assign mism = chk_vld && (ram_rdata != {DATA_W{chk_val}});

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      fail      <= 1'b0;
      fail_addr <= '0;
      fail_elem <= '0;
    end else if (mism && !fail) begin
      fail      <= 1'b1;
      fail_addr <= chk_addr;
      fail_elem <= chk_elem;
    end
  end
endmodule

// File: rtl/march_y_bist.sv
module march_y_bist
  import march_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              ram_we,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [1:0]        fail_elem
);
  st_e        state;
  logic [1:0] elem;
  op_t        op;
  logic       accept, load, load_hi, adv, down, at_end;
  logic       running;

  march_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .at_end(at_end),
    .state(state), .elem(elem), .op(op), .accept(accept),
    .load(load), .load_hi(load_hi), .adv(adv), .down(down)
  );

  march_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(load), .load_hi(load_hi),
    .adv(adv), .down(down), .addr(ram_addr), .at_end(at_end)
  );

  assign running   = (state == ST_RUN);
  assign ram_we    = running && op.is_wr;
  assign ram_wdata = {DATA_W{op.val}};
  assign busy      = running || (state == ST_CHK);
  assign done      = (state == ST_FIN);

  march_resp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_resp (
    .clk(clk), .rst_n(rst_n), .clr(accept),
    .rd_issue(running && !op.is_wr), .exp_val(op.val),
    .addr(ram_addr), .elem(elem), .ram_rdata(ram_rdata),
    .fail(fail), .fail_addr(fail_addr), .fail_elem(fail_elem)
  );
endmodule

// File: rtl/march_y_bist_sva.sv
module march_y_bist_sva #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              ram_we,
  input logic              busy,
  input logic              done,
  input logic              fail,
  input logic [ADDR_W-1:0] fail_addr,
  input logic [1:0]        fail_elem
);
  logic new_run;
  assign new_run = start && !busy;

  AST_WE_ONLY_BUSY:   assert property (@(posedge clk) disable iff (!rst_n) ram_we |-> busy);                              // R9
  AST_DONE_IDLE:      assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);                               // R2
  AST_DONE_PULSE:     assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);                               // R2
  AST_BUSY_TO_DONE:   assert property (@(posedge clk) disable iff (!rst_n) busy |=> (busy || done));                      // R2
  AST_START_IGNORED:  assert property (@(posedge clk) disable iff (!rst_n) (busy && start) |=> (busy || done));           // R7
  AST_FAIL_STICKY:    assert property (@(posedge clk) disable iff (!rst_n) (fail && !new_run) |=> fail);                  // R6
  AST_FAIL_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (fail && !new_run) |=> $stable(fail_addr));    // R6
  AST_FAIL_ELEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (fail && !new_run) |=> $stable(fail_elem));    // R6
  AST_START_CLEARS:   assert property (@(posedge clk) disable iff (!rst_n) new_run |=> !fail);                            // R8
endmodule

bind march_y_bist march_y_bist_sva #(.ADDR_W(ADDR_W)) u_sva (.*);

// File: tb/march_y_bist_bench.sv
module march_y_bist_bench;
  localparam int AW = 8;
  localparam int DW = 18;
  localparam int N  = 1 << AW;
  localparam int OPS = 8 * N;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_wdata;
  logic          ram_we;
  logic [DW-1:0] ram_rdata;
  logic          busy, done, fail;
  logic [AW-1:0] fail_addr;
  logic [1:0]    fail_elem;

  always #2.5 clk = ~clk;

  march_y_bist #(.ADDR_W(AW), .DATA_W(DW)) u_march_y_bist (
    .clk(clk), .rst_n(rst_n), .start(start), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_we(ram_we), .ram_rdata(ram_rdata),
    .busy(busy), .done(done), .fail(fail), .fail_addr(fail_addr),
    .fail_elem(fail_elem)
  );

  // Behavioural RAM with fault injection: 0 none, 1 stuck-at-0, 2 stuck-at-1,
  // 3 write to fault_addr+1 also lands on fault_addr.
  int            fault_mode = 0;
  int            fault_addr = 0;
  int            fault_bit  = 0;
  logic [DW-1:0] mem [N];
  logic [DW-1:0] rd_tmp;

  initial for (int i = 0; i < N; i++) mem[i] = '0;

  always @(posedge clk) begin
    rd_tmp = mem[ram_addr];
    if (fault_mode == 1 && int'(ram_addr) == fault_addr) rd_tmp[fault_bit] = 1'b0;
    if (fault_mode == 2 && int'(ram_addr) == fault_addr) rd_tmp[fault_bit] = 1'b1;
    ram_rdata <= rd_tmp;
    if (ram_we) begin
      mem[ram_addr] <= ram_wdata;
      if (fault_mode == 3 && int'(ram_addr) == fault_addr + 1) mem[fault_addr] <= ram_wdata;
    end
  end

  // Reference operation list
  typedef struct { int addr; bit we; bit val; } ref_op_t;
  ref_op_t q[$];

  function automatic ref_op_t mk(int a, bit w, bit v);
    ref_op_t r;
    r.addr = a; r.we = w; r.val = v;
    return r;
  endfunction

  task automatic build_ops();
    q.delete();
    for (int a = 0; a < N; a++) q.push_back(mk(a, 1, 0));
    for (int a = 0; a < N; a++) begin
      q.push_back(mk(a, 0, 0)); q.push_back(mk(a, 1, 1)); q.push_back(mk(a, 0, 1));
    end
    for (int a = N - 1; a >= 0; a--) begin
      q.push_back(mk(a, 0, 1)); q.push_back(mk(a, 1, 0)); q.push_back(mk(a, 0, 0));
    end
    for (int a = 0; a < N; a++) q.push_back(mk(a, 0, 0));
  endtask

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // One complete run; a second start pulse is sent at op index restart_at (-1 for none).
  task automatic run_march(input bit exp_fail, input int exp_addr, input int exp_elem,
                           input int restart_at);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int k = 0; k < OPS + 2; k++) begin
      if (k == 0) check(fail == 1'b0, "R8", "fail cleared at start", fail, 0);
      if (k < OPS) begin
        check(busy == 1'b1 && done == 1'b0, "R2", "busy during ops", {busy, done}, 2'b10);
        check(int'(ram_addr) == q[k].addr, "R3", "address order", ram_addr, q[k].addr);
        check(ram_we == q[k].we, "R9", "write enable", ram_we, q[k].we);
        if (q[k].we)
          check(ram_wdata == {DW{q[k].val}}, "R4", "write pattern", ram_wdata, {DW{q[k].val}});
      end else if (k == OPS) begin
        check(busy == 1'b1 && done == 1'b0, "R2", "final compare cycle", {busy, done}, 2'b10);
      end else begin
        check(busy == 1'b0 && done == 1'b1, "R2", "done pulse", {busy, done}, 2'b01);
        check(fail == exp_fail, "R6", "fail flag", fail, exp_fail);
        if (exp_fail) begin
          check(int'(fail_addr) == exp_addr, "R6", "fail address", fail_addr, exp_addr);
          check(int'(fail_elem) == exp_elem, "R6", "fail element", fail_elem, exp_elem);
        end
      end
      start = (k == restart_at);  // R7: start while busy
      @(negedge clk);
      start = 1'b0;
    end
    check(done == 1'b0 && busy == 1'b0, "R2", "done is one cycle", {busy, done}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    build_ops();
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && ram_we == 0 && fail == 0, "R1", "in reset",
          {busy, done, ram_we, fail}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 0 && done == 0 && ram_we == 0 && fail == 0, "R1", "after reset",
          {busy, done, ram_we, fail}, 0);

    // Clean RAM passes (R5: compare timing must line up with registered read)
    fault_mode = 0;
    run_march(0, 0, 0, -1);

    // Stuck-at-0 on bit 0 of word 0: first seen on read-ones of element 1
    fault_mode = 1; fault_addr = 0; fault_bit = 0;
    run_march(1, 0, 1, -1);

    // Stuck-at-1 on top bit of last word: first seen on read-zeros of element 1
    fault_mode = 2; fault_addr = N - 1; fault_bit = DW - 1;
    run_march(1, N - 1, 1, -1);

    // Coupling from word 41 onto word 40: only the descending element exposes it
    fault_mode = 3; fault_addr = 40; fault_bit = 0;
    run_march(1, 40, 2, -1);

    // Clean RAM after a failing run, with a stray start mid-run (R7, R8)
    fault_mode = 0;
    run_march(0, 0, 0, 100);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule